// File: doc/BRIEF.md
# Sensor Power Mode Controller

This block holds a sensor's operating mode, which is one of Standby, Ready or Active. Normally two register bits written by the host set the mode: an active request and a ready request. An enable bit can pass control of the active state to an external pin. That pin is shared with an interrupt output. While the enable bit is set, the pin's output driver is turned off and its level is read as a level-sensitive mode request. While the pin is in control, register writes to the active request have no effect, and the readable active bit shows the state that the pin drives.

While the pin is in control, it moves the sensor between Active and one idle mode. The idle mode is either Standby or Ready. It is the one the ready request selected in the cycle the enable bit rose, and it stays fixed until the enable bit is cleared. A move from Standby to Active starts a startup timer, which is 60 ms by default and set from a clock-frequency parameter. The wake-done flag rises when the timer expires. Leaving Active cancels the timer. Ready is a warm state, so a move from Ready to Active raises the flag at once.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is held and after it is released, mode reads Standby (2'b00), active_rd is 0, pin_oe is 1, pin_out is 0 and wake_done is 0.
- R2: With ext_en at 0, one clock after the register bits change, mode reads Active (2'b10) if reg_active is 1, otherwise Ready (2'b01) if reg_ready is 1, otherwise Standby (2'b00).
- R3: With ext_en at 0, pin_oe is 1 and pin_out equals irq_in as it was one clock earlier.
- R4: One clock after ext_en is 1, pin_oe is 0 and pin_out is 0, whatever irq_in is.
- R5: With ext_en at 1, a change of pin_in reaches mode and active_rd on the third rising clock edge after the change. The first two edges load the synchronizer stages.
- R6: With ext_en at 1, reg_active has no effect on mode or active_rd.
- R7: With ext_en at 1, the idle mode that the pin selects is the one that reg_ready picked in the cycle ext_en rose. Later changes of reg_ready have no effect until ext_en returns to 0.
- R8: After a move from Standby to Active, wake_done stays 0 for WAKE_CYC−1 clocks and reads 1 on the WAKE_CYC-th clock after mode first reads Active. WAKE_CYC is CLK_HZ/1000·WAKE_MS.
- R9: Whenever mode is not Active, wake_done is 0. Leaving Active during the startup count cancels it, and the next entry from Standby restarts the full count.
- R10: A move from Ready to Active sets wake_done in the same cycle that mode first reads Active.
- R11: active_rd is 1 exactly when mode reads Active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_active | input | 1 | Register-written active request |
| reg_ready | input | 1 | Register-written ready request |
| ext_en | input | 1 | Hands the active state to the shared pin |
| pin_in | input | 1 | Input level of the shared pin (asynchronous) |
| irq_in | input | 1 | Interrupt value to drive on the shared pin |
| mode | output | 2 | Current mode: 00 Standby, 01 Ready, 10 Active |
| active_rd | output | 1 | Readable active bit |
| pin_oe | output | 1 | Output enable of the shared pin driver |
| pin_out | output | 1 | Value driven on the shared pin |
| wake_done | output | 1 | Startup delay complete after entry to Active |

## Verification
The hardest case to reach is the frozen idle pair. The ready request has to change after the enable bit rises, and the bench must then see that a falling pin still returns the mode to the idle state picked at hand-over. The bench covers this in two passes. One parks in Ready and then clears the ready request. The other parks in Standby and then sets it. Each pass toggles the pin and counts the three edges of synchronizer latency. The cancelled startup count is reached by leaving Active halfway through the timer and re-entering. The bench then checks that the flag is still low one clock before a full fresh count ends.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'b00,
    MODE_READY   = 2'b01,
    MODE_ACTIVE  = 2'b10
  } pmc_mode_e;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pmc_mode_sel.sv
module pmc_mode_sel (
  input  logic clk,
  input  logic rst,
  input  logic ext_en,
  input  logic reg_active,
  input  logic reg_ready,
  input  logic pin_lvl,
  output logic act_want,
  output logic idle_ready
);
  logic en_q;
  logic park_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      park_ready <= 1'b0;
    end else begin
      en_q <= ext_en;
      if (ext_en && !en_q) park_ready <= reg_ready;
    end
  end

  always_comb begin
    act_want   = ext_en ? pin_lvl : reg_active;
    idle_ready = (ext_en && en_q) ? park_ready : reg_ready;
  end

  // R7: idle pair cannot change while the pin stays in control
  p_pair_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (en_q && ext_en) |=> $stable(park_ready));
endmodule

// File: rtl/pmc_wake_timer.sv
module pmc_wake_timer
  import pmc_pkg::*;
#(
  parameter int unsigned CYCLES = 3000000
) (
  input  logic      clk,
  input  logic      rst,
  input  pmc_mode_e cur_mode,
  input  pmc_mode_e nxt_mode,
  output logic      done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (nxt_mode != MODE_ACTIVE) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (cur_mode == MODE_STANDBY) begin
      cnt  <= LOAD;
      done <= 1'b0;
    end else if (cur_mode == MODE_READY) begin
      cnt  <= '0;
      done <= 1'b1;
    end else if (cnt != '0) begin
      cnt  <= cnt - 1'b1;
      done <= (cnt == CW'(1));
    end else begin
      done <= 1'b1;
    end
  end

  // R9: no completion while the count is still running
  p_no_early_done_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt > CW'(1)) |=> !done);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50000000,
  parameter int unsigned WAKE_MS  = 60,
  parameter int          SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_active,
  input  logic       reg_ready,
  input  logic       ext_en,
  input  logic       pin_in,
  input  logic       irq_in,
  output logic [1:0] mode,
  output logic       active_rd,
  output logic       pin_oe,
  output logic       pin_out,
  output logic       wake_done
);
  localparam int unsigned WAKE_CYC = (CLK_HZ / 1000) * WAKE_MS;

  logic      pin_lvl;
  logic      act_want;
  logic      idle_ready;
  pmc_mode_e mode_q, mode_d;
  logic      active_q, oe_q, out_q;

  pmc_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_lvl)
  );

  pmc_mode_sel u_sel (
    .clk(clk), .rst(rst), .ext_en(ext_en), .reg_active(reg_active),
    .reg_ready(reg_ready), .pin_lvl(pin_lvl), .act_want(act_want),
    .idle_ready(idle_ready)
  );

  always_comb begin
    if (act_want)        mode_d = MODE_ACTIVE;
    else if (idle_ready) mode_d = MODE_READY;
    else                 mode_d = MODE_STANDBY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_STANDBY;
      active_q <= 1'b0;
      oe_q     <= 1'b1;
      out_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      active_q <= act_want;
      oe_q     <= !ext_en;
      out_q    <= !ext_en && irq_in;
    end
  end

  pmc_wake_timer #(.CYCLES(WAKE_CYC)) u_timer (
    .clk(clk), .rst(rst), .cur_mode(mode_q), .nxt_mode(mode_d), .done(wake_done)
  );

  assign mode      = mode_q;
  assign active_rd = active_q;
  assign pin_oe    = oe_q;
  assign pin_out   = out_q;

  // R3: interrupt passes through while the pin is an output
  p_irq_pass_r3: assert property (@(posedge clk) disable iff (rst)
    !ext_en |=> (pin_oe && pin_out == $past(irq_in)));
  // R4: driver released while the pin is an input
  p_pin_released_r4: assert property (@(posedge clk) disable iff (rst)
    ext_en |=> (!pin_oe && !pin_out));
  // R6: with the pin in control the active bit tracks the synchronized level
  p_pin_owns_active_r6: assert property (@(posedge clk) disable iff (rst)
    ext_en |=> (active_rd == $past(pin_lvl)));
  // R9: flag only while Active
  p_done_only_active_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_ACTIVE) |-> !wake_done);
  // R11: readable bit agrees with mode
  p_rdbit_agrees_r11: assert property (@(posedge clk) disable iff (rst)
    active_rd == (mode_q == MODE_ACTIVE));
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  localparam int WAKE = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_active = 1'b0, reg_ready = 1'b0, ext_en = 1'b0, pin_in = 1'b0, irq_in = 1'b0;
  logic [1:0] mode;
  logic active_rd, pin_oe, pin_out, wake_done;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.CLK_HZ(1000), .WAKE_MS(WAKE)) dut (
    .clk(clk), .rst(rst), .reg_active(reg_active), .reg_ready(reg_ready),
    .ext_en(ext_en), .pin_in(pin_in), .irq_in(irq_in), .mode(mode),
    .active_rd(active_rd), .pin_oe(pin_oe), .pin_out(pin_out), .wake_done(wake_done)
  );

  // {reg_active, reg_ready, irq_in, exp_mode[1:0], exp_pin_out}
  localparam int NV = 7;
  localparam logic [5:0] VEC [NV] = '{
    6'b001_00_1, 6'b010_01_0, 6'b111_10_1, 6'b100_10_0,
    6'b001_00_1, 6'b011_01_1, 6'b000_00_0
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    step(3);
    chk("R1 mode", mode, 0);
    chk("R1 active_rd", active_rd, 0);
    chk("R1 pin_oe", pin_oe, 1);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 wake_done", wake_done, 0);
    rst = 1'b0;
    step(1);
    chk("R1 mode after release", mode, 0);
    chk("R1 oe after release", pin_oe, 1);

    // R2 / R3 table walk
    for (int v = 0; v < NV; v++) begin
      reg_active = VEC[v][5];
      reg_ready  = VEC[v][4];
      irq_in     = VEC[v][3];
      step(1);
      chk("R2 mode", mode, int'(VEC[v][2:1]));
      chk("R11 active_rd", active_rd, int'(VEC[v][2:1] == 2'b10));
      chk("R3 pin_oe", pin_oe, 1);
      chk("R3 pin_out", pin_out, int'(VEC[v][0]));
    end

    // R8 full startup count from Standby
    reg_active = 1'b1;
    step(1);
    chk("R8 mode active", mode, 2);
    chk("R8 done low at entry", wake_done, 0);
    step(WAKE - 1);
    chk("R8 done low one before", wake_done, 0);
    step(1);
    chk("R8 done high at count", wake_done, 1);

    // R9 cancel and restart
    reg_active = 1'b0;
    step(1);
    chk("R9 done cleared", wake_done, 0);
    reg_active = 1'b1;
    step(10);
    reg_active = 1'b0;
    step(1);
    chk("R9 standby mode", mode, 0);
    chk("R9 done low", wake_done, 0);
    reg_active = 1'b1;
    step(WAKE);
    chk("R9 restart not early", wake_done, 0);
    step(1);
    chk("R9 restart completes", wake_done, 1);

    // R10 from Ready
    reg_active = 1'b0; reg_ready = 1'b1;
    step(1);
    chk("R10 ready", mode, 1);
    reg_active = 1'b1;
    step(1);
    chk("R10 active", mode, 2);
    chk("R10 done immediate", wake_done, 1);

    // Pin control parked in Ready
    reg_active = 1'b0;
    step(1);
    ext_en = 1'b1; irq_in = 1'b1;
    step(1);
    chk("R4 oe released", pin_oe, 0);
    chk("R4 out low", pin_out, 0);
    chk("R7 parked ready", mode, 1);
    reg_ready = 1'b0;
    reg_active = 1'b1;
    step(1);
    chk("R6 reg_active ignored mode", mode, 1);
    chk("R6 reg_active ignored rd", active_rd, 0);
    pin_in = 1'b1;
    step(2);
    chk("R5 not yet at edge 2", mode, 1);
    step(1);
    chk("R5 active at edge 3", mode, 2);
    chk("R6 rd follows pin", active_rd, 1);
    chk("R10 done via pin from ready", wake_done, 1);
    reg_active = 1'b0;
    step(1);
    chk("R6 reg clear ignored", mode, 2);
    pin_in = 1'b0;
    step(3);
    chk("R7 back to parked ready", mode, 1);

    // Pin control parked in Standby
    ext_en = 1'b0;
    step(1);
    chk("R2 standby after hand-back", mode, 0);
    chk("R3 oe restored", pin_oe, 1);
    ext_en = 1'b1;
    step(1);
    reg_ready = 1'b1;
    step(1);
    chk("R7 ready change ignored", mode, 0);
    pin_in = 1'b1;
    step(3);
    chk("R5 active via pin", mode, 2);
    chk("R8 done low from standby", wake_done, 0);
    pin_in = 1'b0;
    step(3);
    chk("R7 returns to standby", mode, 0);
    chk("R9 done low out of active", wake_done, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule